// File: doc/BRIEF.md
# Miss Tracking Pool with Same-Line Chaining

This block keeps a small pool of outstanding-miss entries for a core's load/store path. A requester presents a miss with its line address, a write flag, a texture flag and the issuing warp number. The block either claims a free entry for it, which means one memory request must go out, or finds an outstanding non-texture entry with the same line address. In that case it links the new entry behind the last entry of that entry's chain, and no memory request is issued.

When memory answers, the requester reports the id of the primary entry on the fill port. Every entry chained behind that primary is marked fetched with it. The chain is then offered on the return port, one entry per accepted transfer, primary first and the rest in the order they were allocated. Texture misses never chain. They sit in a separate in-order queue whose oldest entry is offered only once it is fetched. An entry becomes free again in the cycle its return is accepted. The pool reports its occupancy and a high-water mark, and answers whether at least a requested number of entries are free.

The allocate port is valid/ready: a miss is taken in a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_id`, `alloc_merged` and `mreq_valid` describe that cycle's outcome. The return port is valid/ready: a return offered and not taken keeps the same entry and fields until it is taken. The fill port has no back-pressure. It must only name an allocated, unfetched, primary entry.

Top module: `mshr_merge_pool`

## Requirements
- R1: After reset the pool is empty: `used_count` and `high_water` are 0, `ret_valid` is 0 and `alloc_ready` is 1.
- R2: A non-texture miss that matches no unfetched non-texture entry takes the lowest-numbered free entry. It is reported with `alloc_merged`=0 and `mreq_valid`=1.
- R3: A non-texture miss whose line address equals that of an unfetched non-texture entry is chained. It takes the lowest free entry, with `alloc_merged`=1 and `mreq_valid`=0. A miss to the address of an already fetched entry starts a new chain.
- R4: A fill marks the named primary and its whole chain fetched. The chain is then returned primary first, followed by the other entries in allocation order, each with its own warp number.
- R5: Texture misses never chain. They return strictly in allocation order, and the oldest is offered only after it has been fetched, even when a younger one is already fetched.
- R6: When both the general return path and the texture queue have a return ready, the general one is offered. The exception is a texture return already offered and not yet taken, which stays offered.
- R7: While `ret_valid` is 1 and `ret_ready` is 0, `ret_id` and its fields stay unchanged in the next cycle.
- R8: An entry is freed only in the cycle its return is accepted. `used_count` changes by +1 for an accepted miss and by -1 for an accepted return, so both in the same cycle leave it unchanged. An entry being freed cannot be claimed in that same cycle.
- R9: `alloc_ready` is 0 when all 16 entries are in use or when `fill_valid` is 1.
- R10: `avail_ok` is 1 exactly when the number of free entries is at least `avail_need`.
- R11: `high_water` holds the largest `used_count` reached since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Miss presented |
| alloc_ready | output | 1 | Pool can take a miss this cycle |
| alloc_addr | input | ADDR_W | Line address of the miss |
| alloc_write | input | 1 | Miss is a write |
| alloc_tex | input | 1 | Miss is a texture miss |
| alloc_warp | input | WARP_W | Issuing warp number |
| alloc_id | output | ID_W | Entry id given to the miss |
| alloc_merged | output | 1 | Miss was chained behind an outstanding entry |
| mreq_valid | output | 1 | An accepted miss needs a memory request |
| fill_valid | input | 1 | Memory data returned for a primary entry |
| fill_id | input | ID_W | Primary entry id of the fill |
| ret_valid | output | 1 | A fetched entry is offered |
| ret_ready | input | 1 | Consumer takes the offered entry |
| ret_id | output | ID_W | Offered entry id |
| ret_addr | output | ADDR_W | Offered entry line address |
| ret_warp | output | WARP_W | Offered entry warp number |
| ret_write | output | 1 | Offered entry write flag |
| ret_tex | output | 1 | Offered entry came from the texture queue |
| avail_need | input | CNT_W | Number of free entries asked about |
| avail_ok | output | 1 | At least `avail_need` entries are free |
| used_count | output | CNT_W | Entries in use |
| high_water | output | CNT_W | Largest occupancy since reset |

## Verification
Two collisions matter most. The first is an accepted return and an accepted miss in the same cycle. The bench fills one entry and then raises `ret_ready` together with `alloc_valid`. It expects the miss to receive the next lowest id, not the id being freed, and expects `used_count` to stay unchanged. The second is a fill arriving while a texture return is held under back-pressure. The bench expects the held texture entry to stay on the port, and the newly fetched general chain to be offered only once that entry is taken. Chain lengths from one to five and a full pool are swept, with ids, warps and occupancy computed from the allocation order.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_GEN  = 2'd1,
    RS_TEX  = 2'd2
  } ret_src_e;
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index free entry finder.
module mshr_pick #(
  parameter int N_ENT = 16,
  localparam int ID_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] free_v,
  output logic             found,
  output logic [ID_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (free_v[i]) begin
        found = 1'b1;
        idx   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_match.sv
// Parallel line-address compare; returns the chain tail of a hit.
module mshr_match #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  localparam int ID_W  = $clog2(N_ENT)
) (
  input  logic [ADDR_W-1:0] key,
  input  logic [ADDR_W-1:0] addr_tab [N_ENT],
  input  logic [N_ENT-1:0]  cand,
  input  logic [N_ENT-1:0]  has_next,
  output logic              hit,
  output logic [ID_W-1:0]   tail_id
);
  always_comb begin
    hit     = 1'b0;
    tail_id = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (cand[i] && (addr_tab[i] == key)) begin
        hit = 1'b1;
        if (!has_next[i]) tail_id = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_idq.sv
// Small in-order queue of entry ids.
module mshr_idq #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign head  = slot[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/mshr_merge_pool.sv
module mshr_merge_pool #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int WARP_W = 6,
  localparam int ID_W  = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_write,
  input  logic              alloc_tex,
  input  logic [WARP_W-1:0] alloc_warp,
  output logic [ID_W-1:0]   alloc_id,
  output logic              alloc_merged,
  output logic              mreq_valid,
  input  logic              fill_valid,
  input  logic [ID_W-1:0]   fill_id,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [ID_W-1:0]   ret_id,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [WARP_W-1:0] ret_warp,
  output logic              ret_write,
  output logic              ret_tex,
  input  logic [CNT_W-1:0]  avail_need,
  output logic              avail_ok,
  output logic [CNT_W-1:0]  used_count,
  output logic [CNT_W-1:0]  high_water
);
  import mshr_pkg::*;

  // entry state
  logic [N_ENT-1:0]  e_valid, e_fetched, e_tex, e_write, e_nv;
  logic [ADDR_W-1:0] e_addr [N_ENT];
  logic [WARP_W-1:0] e_warp [N_ENT];
  logic [ID_W-1:0]   e_next [N_ENT];

  logic [N_ENT-1:0]  cand, fill_mark;
  logic              free_found, hit, alloc_fire, pop_fire, chain_in;
  logic [ID_W-1:0]   free_idx, tail_id;
  logic [CNT_W-1:0]  used_next;

  // return path state
  logic              cur_v, hold_tex;
  logic [ID_W-1:0]   cur_id;
  logic [ID_W-1:0]   gq_head, tq_head, gen_head;
  logic              gq_empty, tq_empty, gen_rdy, tex_rdy;
  ret_src_e          src;

  assign cand = e_valid & ~e_fetched & ~e_tex;

  mshr_pick #(.N_ENT(N_ENT)) u_pick (
    .free_v (~e_valid),
    .found  (free_found),
    .idx    (free_idx)
  );

  mshr_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_match (
    .key      (alloc_addr),
    .addr_tab (e_addr),
    .cand     (cand),
    .has_next (e_nv),
    .hit      (hit),
    .tail_id  (tail_id)
  );

  // allocate side
  assign alloc_ready  = free_found && !fill_valid;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_id     = free_idx;
  assign alloc_merged = hit && !alloc_tex;
  assign chain_in     = alloc_fire && alloc_merged;
  assign mreq_valid   = alloc_fire && !alloc_merged;

  // fill marks the primary and every unfetched general entry of its line
  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_fill
      assign fill_mark[g] = fill_valid &&
        ((ID_W'(g) == fill_id) ||
         (cand[g] && !e_tex[fill_id] && (e_addr[g] == e_addr[fill_id])));
    end
  endgenerate

  // return queues
  mshr_idq #(.DEPTH(N_ENT), .W(ID_W)) u_genq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fill_valid && !e_tex[fill_id]),
    .push_data (fill_id),
    .pop       (pop_fire && (src == RS_GEN) && !cur_v),
    .head      (gq_head),
    .empty     (gq_empty)
  );

  mshr_idq #(.DEPTH(N_ENT), .W(ID_W)) u_texq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (alloc_fire && alloc_tex),
    .push_data (free_idx),
    .pop       (pop_fire && (src == RS_TEX)),
    .head      (tq_head),
    .empty     (tq_empty)
  );

  assign gen_head = cur_v ? cur_id : gq_head;
  assign gen_rdy  = cur_v || !gq_empty;
  assign tex_rdy  = !tq_empty && e_fetched[tq_head];

  always_comb begin
    if (hold_tex)     src = RS_TEX;
    else if (gen_rdy) src = RS_GEN;
    else if (tex_rdy) src = RS_TEX;
    else              src = RS_NONE;
  end

  assign ret_valid = (src != RS_NONE);
  assign ret_id    = (src == RS_TEX) ? tq_head : gen_head;
  assign ret_addr  = e_addr[ret_id];
  assign ret_warp  = e_warp[ret_id];
  assign ret_write = e_write[ret_id];
  assign ret_tex   = (src == RS_TEX);
  assign pop_fire  = ret_valid && ret_ready;

  // chain cursor and texture hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v    <= 1'b0;
      cur_id   <= '0;
      hold_tex <= 1'b0;
    end else begin
      hold_tex <= (src == RS_TEX) && !ret_ready;
      if (pop_fire && (src == RS_GEN)) begin
        cur_v  <= e_nv[gen_head];
        cur_id <= e_next[gen_head];
      end
    end
  end

  // entry control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid   <= '0;
      e_fetched <= '0;
      e_tex     <= '0;
      e_write   <= '0;
      e_nv      <= '0;
    end else begin
      if (pop_fire) e_valid[ret_id] <= 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
        if (fill_mark[i]) e_fetched[i] <= 1'b1;
      end
      if (alloc_fire) begin
        e_valid[free_idx]   <= 1'b1;
        e_fetched[free_idx] <= 1'b0;
        e_tex[free_idx]     <= alloc_tex;
        e_write[free_idx]   <= alloc_write;
        e_nv[free_idx]      <= 1'b0;
      end
      if (chain_in) e_nv[tail_id] <= 1'b1;
    end
  end

  // entry payload
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      e_addr[free_idx] <= alloc_addr;
      e_warp[free_idx] <= alloc_warp;
    end
    if (chain_in) e_next[tail_id] <= free_idx;
  end

  // occupancy
  assign used_next = used_count + CNT_W'(alloc_fire) - CNT_W'(pop_fire);
  assign avail_ok  = (CNT_W'(N_ENT) - used_count) >= avail_need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_count <= '0;
      high_water <= '0;
    end else begin
      used_count <= used_next;
      if (used_next > high_water) high_water <= used_next;
    end
  end
endmodule

// File: rtl/mshr_merge_pool_chk.sv
module mshr_merge_pool_chk #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int WARP_W = 6,
  localparam int ID_W  = $clog2(N_ENT),
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic              alloc_merged,
  input logic              mreq_valid,
  input logic              fill_valid,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [ID_W-1:0]   ret_id,
  input logic [CNT_W-1:0]  used_count,
  input logic [CNT_W-1:0]  high_water
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R9: no acceptance when full or during a fill
  a_r9_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> ((used_count < CNT_W'(N_ENT)) && !fill_valid));

  // R3: a chained miss issues no memory request
  a_r3_merge_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && alloc_merged) |-> !mreq_valid);

  // R7: an offered return is held under back-pressure
  a_r7_hold_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_id)));

  // R11: the high-water mark never trails occupancy
  a_r11_high_water: assert property (@(posedge clk) disable iff (!rst_n)
    high_water >= used_count);

  // R8: occupancy moves only with accepted misses and returns
  a_r8_used_step: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (used_count == $past(used_count)
                + CNT_W'($past(alloc_valid && alloc_ready))
                - CNT_W'($past(ret_valid && ret_ready))));
endmodule

bind mshr_merge_pool mshr_merge_pool_chk #(
  .N_ENT(N_ENT), .ADDR_W(ADDR_W), .WARP_W(WARP_W)
) u_chk (.*);

// File: tb/mshr_merge_pool_tb.sv
module mshr_merge_pool_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_write = 1'b0, alloc_tex = 1'b0;
  logic [31:0] alloc_addr = '0;
  logic [5:0]  alloc_warp = '0;
  logic        alloc_ready, alloc_merged, mreq_valid;
  logic [3:0]  alloc_id;
  logic        fill_valid = 1'b0;
  logic [3:0]  fill_id = '0;
  logic        ret_valid, ret_write, ret_tex;
  logic        ret_ready = 1'b0;
  logic [3:0]  ret_id;
  logic [31:0] ret_addr;
  logic [5:0]  ret_warp;
  logic [4:0]  avail_need = '0;
  logic        avail_ok;
  logic [4:0]  used_count, high_water;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mshr_merge_pool u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [31:0] a, input logic tex, input logic [5:0] w,
                          output logic [3:0] id, output logic mg, output logic mq);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_addr = a; alloc_tex = tex; alloc_warp = w;
    alloc_write = w[0];
    #1 id = alloc_id; mg = alloc_merged; mq = mreq_valid;
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [3:0] id);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = id;
    @(posedge clk); #1 fill_valid = 1'b0;
  endtask

  task automatic do_pop(output logic v, output logic [3:0] id, output logic [5:0] w);
    @(negedge clk);
    v = ret_valid; id = ret_id; w = ret_warp;
    ret_ready = 1'b1;
    @(posedge clk); #1 ret_ready = 1'b0;
  endtask

  initial begin
    logic [3:0] id; logic mg, mq, v; logic [5:0] w;
    int hw;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 used", used_count, 0);
    check("R1 high", high_water, 0);
    check("R1 ret_valid", ret_valid, 0);
    check("R1 ready", alloc_ready, 1);
    avail_need = 5'd16; #1 check("R10 all free", avail_ok, 1);

    // chain sweep: lengths 1..5
    hw = 0;
    for (int len = 1; len <= 5; len++) begin
      for (int k = 0; k < len; k++) begin
        do_alloc(32'h40 + len, 1'b0, 6'(k + 1), id, mg, mq);
        check("R2 R3 id", id, k);
        check("R3 merged", mg, (k > 0));
        check("R2 R3 mreq", mq, (k == 0));
      end
      if (len > hw) hw = len;
      check("R11 high", high_water, hw);
      do_fill(4'd0);
      for (int k = 0; k < len; k++) begin
        do_pop(v, id, w);
        check("R4 valid", v, 1);
        check("R4 order", id, k);
        check("R4 warp", w, k + 1);
      end
      @(negedge clk);
      check("R8 drained", used_count, 0);
      check("R4 no extra", ret_valid, 0);
    end

    // fetched entry does not attract merges (R3)
    do_alloc(32'h80, 1'b0, 6'd3, id, mg, mq);
    do_fill(4'd0);
    do_alloc(32'h80, 1'b0, 6'd4, id, mg, mq);
    check("R3 after fetch merged", mg, 0);
    check("R3 after fetch id", id, 1);
    // same-cycle accepted return and miss (R8)
    @(negedge clk);
    ret_ready = 1'b1; alloc_valid = 1'b1; alloc_addr = 32'h90; alloc_tex = 1'b0;
    #1 check("R8 ret id", ret_id, 0);
    check("R8 no reuse", alloc_id, 2);
    @(posedge clk); #1 ret_ready = 1'b0; alloc_valid = 1'b0;
    @(negedge clk);
    check("R8 used same", used_count, 2);
    // fill stalls allocation (R9)
    @(negedge clk);
    fill_valid = 1'b1; fill_id = 4'd1; alloc_valid = 1'b1;
    #1 check("R9 fill stall", alloc_ready, 0);
    check("R9 no mreq", mreq_valid, 0);
    @(posedge clk); #1 fill_valid = 1'b0; alloc_valid = 1'b0;
    do_pop(v, id, w); check("R4 entry1", id, 1);
    do_fill(4'd2);
    do_pop(v, id, w); check("R4 entry2", id, 2);

    // texture ordering, priority, hold (R5 R6 R7)
    do_alloc(32'h300, 1'b0, 6'd7, id, mg, mq); check("R2 gen id", id, 0);
    do_alloc(32'h300, 1'b1, 6'd8, id, mg, mq);
    check("R5 tex no merge", mg, 0); check("R5 tex id", id, 1);
    do_alloc(32'h304, 1'b1, 6'd9, id, mg, mq); check("R5 tex id2", id, 2);
    do_fill(4'd2);
    @(negedge clk); check("R5 young waits", ret_valid, 0);
    do_fill(4'd1);
    @(negedge clk); check("R5 oldest", ret_id, 1); check("R5 tex flag", ret_tex, 1);
    do_fill(4'd0);
    @(negedge clk); check("R7 held id", ret_id, 1); check("R7 held tex", ret_tex, 1);
    do_pop(v, id, w); check("R7 popped", id, 1); check("R5 warp", w, 8);
    @(negedge clk); check("R6 general first", ret_id, 0); check("R6 gen tex", ret_tex, 0);
    do_pop(v, id, w); check("R6 gen pop", id, 0);
    do_pop(v, id, w); check("R5 second tex", id, 2);

    // full pool (R9 R10 R11)
    for (int k = 0; k < N; k++) begin
      do_alloc(32'h1000 + 32'(k), 1'b0, 6'(k), id, mg, mq);
      check("R2 fill id", id, k);
    end
    @(negedge clk);
    check("R9 full", alloc_ready, 0);
    avail_need = 5'd1; #1 check("R10 none", avail_ok, 0);
    avail_need = 5'd0; #1 check("R10 zero", avail_ok, 1);
    check("R11 full", high_water, 16);
    for (int k = N - 1; k >= 0; k--) do_fill(4'(k));
    for (int k = N - 1; k >= 0; k--) begin
      do_pop(v, id, w); check("R4 fill order", id, k);
      if (k == 12) begin
        @(negedge clk);
        avail_need = 5'd4; #1 check("R10 four", avail_ok, 1);
        avail_need = 5'd5; #1 check("R10 five", avail_ok, 0);
      end
    end
    @(negedge clk);
    check("R8 empty", used_count, 0);
    check("R11 kept", high_water, 16);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule